// File: doc/BRIEF.md
# Per-Field Parallel Action Array

This block rewrites a packet header vector after a table lookup has chosen an action. The vector holds a fixed number of equal-width field slots. Each slot has its own small action unit. A lookup result supplies an action index and a few action-data words. The index selects one wide instruction entry, which holds one short instruction per field slot plus a port-mask directive. Every unit executes its own instruction in the same cycle and writes only its own slot. The block also rewrites the packet's destination-port mask. When that mask ends up empty, the drop flag is raised.

All units read their operands from the vector as it arrived, never from another unit's new result. A shift of headers across slots therefore lands as one step. Removing an outer label and moving the inner labels up needs only one entry: each slot copies its neighbour. A decrement serves hop-count handling. An unsigned minimum against action data serves rate stamping. The instruction entries are loaded through a simple write port, one slot at a time. The result is registered and leaves one cycle after the input.

Top module: `vliw_action_array`

## Requirements
- R1: While reset is applied and after it is released, valid_o, port_mask_o, drop_o and hdr_o are all zero. Every instruction entry resets to no-operation with the port mask kept.
- R2: valid_o equals valid_i delayed by one clock. hdr_o, port_mask_o and drop_o change only in the cycle after valid_i is high, and they hold their values otherwise.
- R3: A config write (cfg_we_i high) stores cfg_wdata_i into entry cfg_addr_i. Slots 0 to NUM_FIELDS-1 hold the instructions of the field units. Slot NUM_FIELDS holds the port directive in bits [1:0]. Writes to higher slots change nothing.
- R4: A field instruction is 27 bits: opcode [26:23], operand-A select [22:18], operand-B select [17:13], operand-C select [12:8] and an 8-bit immediate [7:0]. The opcodes are 0 none, 1 copy A, 2 A+B, 3 A-B, 4 A&B, 5 A|B, 6 A^B, 7 unsigned min, 8 unsigned max, 9 A-1. Codes 10 to 15 act as none.
- R5: Operand select codes: 0 to 15 pick an incoming header field, 16 to 19 pick an action-data word, 20 picks the immediate zero-extended, 21 picks all ones, and 22 to 31 pick zero.
- R6: Arithmetic wraps modulo 2^32. Min and max compare as unsigned numbers.
- R7: Operand C is a bit write-mask. The new field is (old & ~C) | (result & C). Opcode none leaves the field unchanged whatever C is.
- R8: All operands come from the incoming vector, so copies between neighbouring fields in one entry move every field at the same time.
- R9: Port directive codes: 0 keeps the mask, 1 loads it from the low NUM_PORTS bits of action-data word 0, 2 ORs those bits into it, and 3 clears it.
- R10: drop_o is high exactly when the resulting port mask is all zero.
- R11: The action index selects which entry runs, and the entries are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input vector valid |
| hdr_i | input | NUM_FIELDS*FIELD_W | Incoming header vector, field k at bits [k*FIELD_W +: FIELD_W] |
| act_idx_i | input | log2(IMEM_DEPTH) | Action index from the lookup |
| act_data_i | input | NUM_DATA*FIELD_W | Action-data words from the lookup |
| port_mask_i | input | NUM_PORTS | Incoming destination-port mask |
| cfg_we_i | input | 1 | Instruction write enable |
| cfg_addr_i | input | log2(IMEM_DEPTH) | Entry being written |
| cfg_slot_i | input | log2(NUM_FIELDS+1) | Slot in the entry being written |
| cfg_wdata_i | input | 27 | Instruction word |
| valid_o | output | 1 | Output vector valid |
| hdr_o | output | NUM_FIELDS*FIELD_W | Rewritten header vector |
| port_mask_o | output | NUM_PORTS | Resulting port mask |
| drop_o | output | 1 | Resulting port mask is empty |

## Verification
The bench builds the block with its defaults: 16 fields of 32 bits, 4 action-data words, 16 entries and 16 ports. With 16 fields and 4 data words, the 5-bit selector leaves codes 22 to 31 unused, and random words reach them along with the unused opcodes 10 to 15. The 32-bit width makes the wrap at zero and at all-ones reachable with directed values. With only 16 entries, the random phase rewrites every entry several times while streaming packets back to back and with gaps.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int SEL_W   = 5;
  localparam int IMM_W   = 8;
  localparam int INSTR_W = 4 + 3 * SEL_W + IMM_W;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_SET = 4'd1, OP_ADD = 4'd2, OP_SUB = 4'd3, OP_AND = 4'd4,
    OP_OR  = 4'd5, OP_XOR = 4'd6, OP_MIN = 4'd7, OP_MAX = 4'd8, OP_DEC = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    PM_KEEP = 2'd0, PM_LOAD = 2'd1, PM_MERGE = 2'd2, PM_CLEAR = 2'd3
  } port_mode_e;

  typedef struct packed {
    logic [3:0]       op;
    logic [SEL_W-1:0] sel_a;
    logic [SEL_W-1:0] sel_b;
    logic [SEL_W-1:0] sel_c;
    logic [IMM_W-1:0] imm;
  } unit_instr_t;
endpackage

// File: rtl/vliw_imem.sv
module vliw_imem import vliw_pkg::*; #(
  parameter int NUM_FIELDS = 16,
  parameter int DEPTH      = 16,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int SLOT_W    = $clog2(NUM_FIELDS + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_we_i,
  input  logic [IDX_W-1:0]             cfg_addr_i,
  input  logic [SLOT_W-1:0]            cfg_slot_i,
  input  logic [INSTR_W-1:0]           cfg_wdata_i,
  input  logic [IDX_W-1:0]             rd_addr_i,
  output unit_instr_t [NUM_FIELDS-1:0] rd_units_o,
  output logic [1:0]                   rd_pmode_o
);
  unit_instr_t [NUM_FIELDS-1:0] units_q [DEPTH];
  logic [1:0]                   pmode_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) begin
        units_q[e] <= '0;
        pmode_q[e] <= PM_KEEP;
      end
    end else if (cfg_we_i) begin
      for (int s = 0; s < NUM_FIELDS; s++) begin
        if (cfg_slot_i == SLOT_W'(s)) units_q[cfg_addr_i][s] <= unit_instr_t'(cfg_wdata_i);
      end
      if (cfg_slot_i == SLOT_W'(NUM_FIELDS)) pmode_q[cfg_addr_i] <= cfg_wdata_i[1:0];
    end
  end

  assign rd_units_o = units_q[rd_addr_i];
  assign rd_pmode_o = pmode_q[rd_addr_i];
endmodule

// File: rtl/vliw_action_unit.sv
module vliw_action_unit import vliw_pkg::*; #(
  parameter int NUM_FIELDS = 16,
  parameter int FIELD_W    = 32,
  parameter int NUM_DATA   = 4,
  parameter int SLOT       = 0,
  localparam int FI_W      = $clog2(NUM_FIELDS),
  localparam int DI_W      = $clog2(NUM_DATA)
) (
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] hdr_i,
  input  logic [NUM_DATA-1:0][FIELD_W-1:0]   data_i,
  input  unit_instr_t                        instr_i,
  output logic [FIELD_W-1:0]                 field_o
);
  localparam logic [SEL_W-1:0] SEL_DATA = SEL_W'(NUM_FIELDS);
  localparam logic [SEL_W-1:0] SEL_IMM  = SEL_W'(NUM_FIELDS + NUM_DATA);
  localparam logic [SEL_W-1:0] SEL_ONES = SEL_W'(NUM_FIELDS + NUM_DATA + 1);

  logic [FIELD_W-1:0] own, a_op, b_op, c_op, alu;

  function automatic logic [FIELD_W-1:0] pick(input logic [SEL_W-1:0] s,
                                              input logic [IMM_W-1:0] imm);
    logic [SEL_W-1:0] d;
    d = s - SEL_DATA;
    if (s < SEL_DATA)      return hdr_i[s[FI_W-1:0]];
    else if (s < SEL_IMM)  return data_i[d[DI_W-1:0]];
    else if (s == SEL_IMM) return FIELD_W'(imm);
    else if (s == SEL_ONES) return '1;
    else                   return '0;
  endfunction

  assign own  = hdr_i[SLOT];
  assign a_op = pick(instr_i.sel_a, instr_i.imm);
  assign b_op = pick(instr_i.sel_b, instr_i.imm);
  assign c_op = pick(instr_i.sel_c, instr_i.imm);

  always_comb begin
    case (instr_i.op)
      OP_SET:  alu = a_op;
      OP_ADD:  alu = a_op + b_op;
      OP_SUB:  alu = a_op - b_op;
      OP_AND:  alu = a_op & b_op;
      OP_OR:   alu = a_op | b_op;
      OP_XOR:  alu = a_op ^ b_op;
      OP_MIN:  alu = (a_op < b_op) ? a_op : b_op;
      OP_MAX:  alu = (a_op > b_op) ? a_op : b_op;
      OP_DEC:  alu = a_op - FIELD_W'(1);
      default: alu = own;
    endcase
  end

  // C operand selects which bits take the new value
  assign field_o = (own & ~c_op) | (alu & c_op);

  always_comb begin
    if (instr_i.op == OP_MIN && c_op == '1) begin
      p_min_bound_r6: assert (field_o <= a_op && field_o <= b_op)
        else $error("min result exceeds an operand");
    end
    if (instr_i.op == OP_NOP) begin
      p_nop_keeps_r7: assert (field_o == own) else $error("nop changed field");
    end
  end
endmodule

// File: rtl/vliw_port_unit.sv
module vliw_port_unit import vliw_pkg::*; #(
  parameter int NUM_PORTS = 16,
  parameter int FIELD_W   = 32
) (
  input  logic [1:0]           mode_i,
  input  logic [NUM_PORTS-1:0] mask_i,
  input  logic [FIELD_W-1:0]   data0_i,
  output logic [NUM_PORTS-1:0] mask_o
);
  always_comb begin
    case (port_mode_e'(mode_i))
      PM_LOAD:  mask_o = data0_i[NUM_PORTS-1:0];
      PM_MERGE: mask_o = mask_i | data0_i[NUM_PORTS-1:0];
      PM_CLEAR: mask_o = '0;
      default:  mask_o = mask_i;
    endcase
  end
endmodule

// File: rtl/vliw_action_array.sv
module vliw_action_array import vliw_pkg::*; #(
  parameter int NUM_FIELDS = 16,
  parameter int FIELD_W    = 32,
  parameter int IMEM_DEPTH = 16,
  parameter int NUM_DATA   = 4,
  parameter int NUM_PORTS  = 16
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   valid_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0]          hdr_i,
  input  logic [$clog2(IMEM_DEPTH)-1:0]          act_idx_i,
  input  logic [NUM_DATA*FIELD_W-1:0]            act_data_i,
  input  logic [NUM_PORTS-1:0]                   port_mask_i,
  input  logic                                   cfg_we_i,
  input  logic [$clog2(IMEM_DEPTH)-1:0]          cfg_addr_i,
  input  logic [$clog2(NUM_FIELDS+1)-1:0]        cfg_slot_i,
  input  logic [INSTR_W-1:0]                     cfg_wdata_i,
  output logic                                   valid_o,
  output logic [NUM_FIELDS*FIELD_W-1:0]          hdr_o,
  output logic [NUM_PORTS-1:0]                   port_mask_o,
  output logic                                   drop_o
);
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] hdr_v, hdr_new;
  logic [NUM_DATA-1:0][FIELD_W-1:0]   data_v;
  unit_instr_t [NUM_FIELDS-1:0]       instrs;
  logic [1:0]                         pmode;
  logic [NUM_PORTS-1:0]               mask_new;

  assign hdr_v  = hdr_i;
  assign data_v = act_data_i;

  vliw_imem #(.NUM_FIELDS(NUM_FIELDS), .DEPTH(IMEM_DEPTH)) i_imem (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_slot_i, .cfg_wdata_i,
    .rd_addr_i(act_idx_i), .rd_units_o(instrs), .rd_pmode_o(pmode)
  );

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_unit
    vliw_action_unit #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W),
                       .NUM_DATA(NUM_DATA), .SLOT(f)) i_unit (
      .hdr_i(hdr_v), .data_i(data_v), .instr_i(instrs[f]), .field_o(hdr_new[f])
    );
  end

  vliw_port_unit #(.NUM_PORTS(NUM_PORTS), .FIELD_W(FIELD_W)) i_ports (
    .mode_i(pmode), .mask_i(port_mask_i), .data0_i(data_v[0]), .mask_o(mask_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      hdr_o       <= '0;
      port_mask_o <= '0;
      drop_o      <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        hdr_o       <= hdr_new;
        port_mask_o <= mask_new;
        drop_o      <= (mask_new == '0);
      end
    end
  end

  p_valid_delay_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(hdr_o) && $stable(port_mask_o) && $stable(drop_o));
  p_drop_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (drop_o == (port_mask_o == '0)));
  p_clear_drops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && pmode == PM_CLEAR |=> drop_o && port_mask_o == '0);
endmodule

// File: tb/test_vliw_action_array.sv
module test_vliw_action_array;
  localparam int NF = 16, FW = 32, DEP = 16, ND = 4, NP = 16, IW = 27;

  logic clk = 0, rst_n = 0;
  logic valid_i = 0;
  logic [NF*FW-1:0] hdr_i = '0;
  logic [3:0] idx_i = '0;
  logic [ND*FW-1:0] data_i = '0;
  logic [NP-1:0] mask_i = '0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = '0;
  logic [4:0] cfg_slot = '0;
  logic [IW-1:0] cfg_wdata = '0;
  logic valid_o, drop_o;
  logic [NF*FW-1:0] hdr_o;
  logic [NP-1:0] mask_o;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [IW-1:0] bim [DEP][NF+1];
  logic [NF*FW-1:0] exp_hdr;
  logic [NP-1:0] exp_mask;
  logic exp_drop;

  always #2 clk = ~clk;

  vliw_action_array i_vliw_action_array (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .hdr_i(hdr_i), .act_idx_i(idx_i),
    .act_data_i(data_i), .port_mask_i(mask_i), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_slot_i(cfg_slot), .cfg_wdata_i(cfg_wdata), .valid_o(valid_o), .hdr_o(hdr_o),
    .port_mask_o(mask_o), .drop_o(drop_o)
  );

  task automatic chk(input bit ok, input string req, input logic [NF*FW-1:0] act,
                     input logic [NF*FW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] mk(input int op, input int sa, input int sb,
                                       input int sc, input int imm);
    return {4'(op), 5'(sa), 5'(sb), 5'(sc), 8'(imm)};
  endfunction

  function automatic logic [FW-1:0] pick_b(input logic [4:0] s, input logic [7:0] imm,
                                           input logic [NF*FW-1:0] h, input logic [ND*FW-1:0] d);
    if (s < 16) return h[s*FW +: FW];
    if (s < 20) return d[(s-16)*FW +: FW];
    if (s == 20) return {24'd0, imm};
    if (s == 21) return '1;
    return '0;
  endfunction

  // reference model per R4-R10
  task automatic model(input logic [3:0] ix, input logic [NF*FW-1:0] h,
                       input logic [ND*FW-1:0] d, input logic [NP-1:0] m);
    for (int f = 0; f < NF; f++) begin
      logic [IW-1:0] w;
      logic [FW-1:0] a, b, c, r, own;
      w = bim[ix][f];
      own = h[f*FW +: FW];
      a = pick_b(w[22:18], w[7:0], h, d);
      b = pick_b(w[17:13], w[7:0], h, d);
      c = pick_b(w[12:8], w[7:0], h, d);
      case (w[26:23])
        1: r = a;  2: r = a + b;  3: r = a - b;  4: r = a & b;  5: r = a | b;
        6: r = a ^ b;  7: r = (a < b) ? a : b;  8: r = (a > b) ? a : b;
        9: r = a - 1;  default: r = own;
      endcase
      exp_hdr[f*FW +: FW] = (own & ~c) | (r & c);
    end
    case (bim[ix][NF][1:0])
      2'd1: exp_mask = d[NP-1:0];
      2'd2: exp_mask = m | d[NP-1:0];
      2'd3: exp_mask = '0;
      default: exp_mask = m;
    endcase
    exp_drop = (exp_mask == '0);
  endtask

  task automatic cfg(input int a, input int s, input logic [IW-1:0] w);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_slot = 5'(s); cfg_wdata = w;
    if (s <= NF) bim[a][s] = w;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // one packet, idle after, checked at next negedge
  task automatic send(input int ix, input logic [NF*FW-1:0] h, input logic [ND*FW-1:0] d,
                      input logic [NP-1:0] m, input string req);
    @(negedge clk);
    valid_i = 1; idx_i = 4'(ix); hdr_i = h; data_i = d; mask_i = m;
    model(4'(ix), h, d, m);
    @(negedge clk);
    valid_i = 0;
    chk(valid_o === 1'b1, {req, " valid"}, NF*FW'(valid_o), 1);
    chk(hdr_o === exp_hdr, {req, " hdr"}, hdr_o, exp_hdr);
    chk(mask_o === exp_mask && drop_o === exp_drop, {req, " mask/drop"},
        NF*FW'({mask_o, drop_o}), NF*FW'({exp_mask, exp_drop}));
  endtask

  function automatic logic [NF*FW-1:0] rnd_hdr();
    logic [NF*FW-1:0] v;
    for (int k = 0; k < NF; k++) v[k*FW +: FW] = $urandom;
    return v;
  endfunction

  function automatic logic [ND*FW-1:0] rnd_data();
    logic [ND*FW-1:0] v;
    for (int k = 0; k < ND; k++) v[k*FW +: FW] = $urandom;
    return v;
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NF*FW-1:0] h, prev_hdr;
    logic [ND*FW-1:0] d;
    logic [NP-1:0] prev_mask;
    logic prev_drop, prev_v;
    void'($urandom(32'd20240611));
    for (int e = 0; e < DEP; e++) for (int s = 0; s <= NF; s++) bim[e][s] = '0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(valid_o === 0 && hdr_o === '0 && mask_o === '0 && drop_o === 0, "R1 in reset",
        hdr_o, '0);
    rst_n = 1;
    @(negedge clk);
    chk(valid_o === 0 && hdr_o === '0 && mask_o === '0 && drop_o === 0, "R1 after reset",
        hdr_o, '0);

    // R1/R3 reset entries pass data unchanged
    send(5, rnd_hdr(), rnd_data(), 16'hA5A5, "R1 R3 reset nop entry");

    // R4 R6 hop-count decrement, wrap at zero
    cfg(1, 2, mk(9, 2, 0, 21, 0));
    h = rnd_hdr(); h[2*FW +: FW] = 32'd64;
    send(1, h, rnd_data(), 16'h0003, "R4 R6 decrement");
    h[2*FW +: FW] = 32'd0;
    send(1, h, rnd_data(), 16'h0003, "R6 decrement wrap");

    // R5 R6 rate stamping via min against data word 1
    cfg(2, 5, mk(7, 5, 17, 21, 0));
    h = rnd_hdr(); h[5*FW +: FW] = 32'hFFFF_0000;
    d = rnd_data(); d[1*FW +: FW] = 32'h0000_1234;
    send(2, h, d, 16'h0001, "R5 R6 min lower data");
    d[1*FW +: FW] = 32'hFFFF_FFFF;
    send(2, h, d, 16'h0001, "R6 min keeps field");

    // R8 label shift: 8<-9, 9<-10, 10<-imm zero
    cfg(3, 8, mk(1, 9, 0, 21, 0));
    cfg(3, 9, mk(1, 10, 0, 21, 0));
    cfg(3, 10, mk(1, 20, 0, 21, 0));
    send(3, rnd_hdr(), rnd_data(), 16'h0010, "R8 label shift");

    // R9 R10 clear drops, load gives multicast, merge ORs
    cfg(4, NF, IW'(3));
    send(4, rnd_hdr(), rnd_data(), 16'hFFFF, "R9 R10 clear drops");
    cfg(6, NF, IW'(1));
    d = rnd_data(); d[15:0] = 16'h0305;
    send(6, rnd_hdr(), d, 16'h8000, "R9 load multicast");
    d[15:0] = 16'h0000;
    send(6, rnd_hdr(), d, 16'h8000, "R10 load empty drops");
    cfg(8, NF, IW'(2));
    d[15:0] = 16'h0044;
    send(8, rnd_hdr(), d, 16'h1001, "R9 merge");

    // R7 write mask from data word 2; R5 unused select codes give zero
    cfg(7, 0, mk(5, 0, 20, 18, 8'hF0));
    cfg(7, 1, mk(2, 25, 31, 21, 0));
    d = rnd_data(); d[2*FW +: FW] = 32'h0000_00C3;
    send(7, rnd_hdr(), d, 16'h0002, "R7 R5 masked write");

    // R3 slot above NF ignored; R11 other entries untouched
    cfg(7, NF + 1, mk(1, 20, 0, 21, 8'h55));
    send(7, rnd_hdr(), d, 16'h0002, "R3 high slot ignored");
    send(1, rnd_hdr(), rnd_data(), 16'h0004, "R11 entry isolation");

    // R2 hold while idle
    @(negedge clk);
    prev_hdr = hdr_o; prev_mask = mask_o; prev_drop = drop_o;
    hdr_i = rnd_hdr(); mask_i = 16'h7777; idx_i = 4'd6;
    @(negedge clk);
    chk(valid_o === 0 && hdr_o === prev_hdr && mask_o === prev_mask && drop_o === prev_drop,
        "R2 hold while idle", hdr_o, prev_hdr);

    // random phase: reconfigure, then stream
    for (int round = 0; round < 20; round++) begin
      for (int k = 0; k < 24; k++)
        cfg($urandom_range(0, DEP - 1), $urandom_range(0, NF + 1), IW'($urandom));
      prev_v = 0;
      for (int n = 0; n < 60; n++) begin
        @(negedge clk);
        if (prev_v) begin
          chk(valid_o === 1 && hdr_o === exp_hdr, "R2 R4 R5 R11 random hdr", hdr_o, exp_hdr);
          chk(mask_o === exp_mask && drop_o === exp_drop, "R9 R10 random mask",
              NF*FW'({mask_o, drop_o}), NF*FW'({exp_mask, exp_drop}));
        end else if (n > 0) begin
          chk(valid_o === 0 && hdr_o === exp_hdr && mask_o === exp_mask, "R2 random idle hold",
              hdr_o, exp_hdr);
        end
        prev_v = ($urandom_range(0, 3) != 0);
        valid_i = prev_v; idx_i = 4'($urandom); hdr_i = rnd_hdr(); data_i = rnd_data();
        mask_i = NP'($urandom);
        if ($urandom_range(0, 7) == 0) mask_i = '0;
        if (prev_v) model(idx_i, hdr_i, data_i, mask_i);
      end
      @(negedge clk);
      if (prev_v) chk(hdr_o === exp_hdr && mask_o === exp_mask, "R11 random last", hdr_o, exp_hdr);
      valid_i = 0;
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule